// File: doc/BRIEF.md
# Programmable Sleep Wake-Up Timer

This block brings a processor back out of a low-power state after a programmed number of seconds. Software writes an 8-bit duration, sets an arm bit, and then requests either full sleep or a display-only mode. The request pulls the internal wake line low, which holds the processor in reset. From then on the block counts one-second ticks that arrive from a real-time clock. After duration plus one ticks the wake line rises, a timer wake flag is raised, and a short release pipeline lets the processor out of reset a fixed number of slow-clock cycles later.

The arm bit survives a wake-up. Software can therefore go back to sleep over and over with a single request each time, and every request restarts the countdown from the held duration. The duration register models non-volatile storage: reset does not touch it. Arming takes a few slow-clock cycles to settle. A request that comes too soon after arming, or one made while disarmed, still puts the processor to sleep, but no timer wake will follow.

Top module: `sleep_wake_timer`

## Requirements
- R1: While rst_ni is low and after it is released, wake_o is 1, cpu_run_o is 1, tmr_flag_o is 0 and the timer is disarmed.
- R2: When wake_o is 1 and sleep_req_i or lcd_req_i is 1 at a rising clock edge, wake_o and cpu_run_o are 0 after that edge and tmr_flag_o is cleared.
- R3: After an accepted armed request with duration D, wake_o rises on the (D+1)-th tick. The change appears at the third rising clock edge after pps_i rises and not earlier.
- R4: tmr_flag_o rises together with wake_o on a timer wake. It stays 1 until the next accepted sleep or display-only request.
- R5: cpu_run_o is 0 whenever wake_o is 0. It rises exactly two clock cycles after wake_o rises, which is within three cycles.
- R6: The timer stays armed after a timer wake. A later request with no new arming restarts the countdown from the held duration.
- R7: A request made while disarmed drops wake_o as in R2. This applies whether the timer was never armed since reset or was disarmed through arm_clr_i. In that case ticks have no effect and wake_o and tmr_flag_o stay 0 until reset.
- R8: If arm_set_i is sampled at edge k, a request sampled at edge k+3 or later starts the countdown. A request at edge k, k+1 or k+2 behaves as disarmed (R7).
- R9: A pps_i pulse counts as exactly one tick however many cycles it stays high. Between ticks, pps_i must be low for at least two cycles.
- R10: The duration register keeps its value through rst_ni. After reset, arming with no new write uses the previously written duration.
- R11: While wake_o is 0, duration writes, arm set, arm clear and further requests have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow (32 kHz class) clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pps_i | input | 1 | One-second tick from the real-time clock, asynchronous |
| dur_we_i | input | 1 | Write strobe for the duration register |
| dur_i | input | 8 | Duration value; wake delay is dur_i+1 seconds |
| arm_set_i | input | 1 | Arm the timer and preset the count |
| arm_clr_i | input | 1 | Disarm the timer |
| sleep_req_i | input | 1 | Sleep-mode entry strobe |
| lcd_req_i | input | 1 | Display-only-mode entry strobe |
| wake_o | output | 1 | Internal wake line; low holds the processor in reset |
| cpu_run_o | output | 1 | Processor release after the wake pipeline |
| tmr_flag_o | output | 1 | Timer was the wake cause |

## Verification
The countdown is exercised with durations from zero upward, entered through either request strobe. This separates the plus-one length and the exact tick-to-wake latency from an off-by-one error in either direction. Long-held tick pulses separate a true edge detector from level counting. A run of back-to-back sleeps with no re-arming, with duration and arm writes issued while asleep, shows whether the held configuration is kept or overwritten. Requests at two and three cycles after arming, a request after disarming, and a reset between write and use each probe the settle window, the idle path and the retention of the duration.

// File: rtl/swt_pkg.sv
package swt_pkg;

  typedef enum logic [1:0] {
    SWT_AWAKE = 2'd0,
    SWT_COUNT = 2'd1,
    SWT_HALT  = 2'd2
  } swt_state_e;

endpackage

// File: rtl/swt_tick_sync.sv
module swt_tick_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pps_i,
  output logic tick_o
);

  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN_W-2:0], pps_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  // rising edge of the synchronised tick
  assign tick_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

  assert_single_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o)
    else $error("tick pulse longer than one cycle");

endmodule

// File: rtl/swt_arm_ctrl.sv
module swt_arm_ctrl #(
  parameter int DUR_W      = 8,
  parameter int SETTLE_CYC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             awake_i,
  input  logic             dur_we_i,
  input  logic [DUR_W-1:0] dur_i,
  input  logic             arm_set_i,
  input  logic             arm_clr_i,
  output logic [DUR_W-1:0] dur_o,
  output logic             arm_load_o,
  output logic             armed_ready_o
);

  localparam int                 SETTLE_W    = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [SETTLE_W-1:0] SETTLE_LAST = SETTLE_W'(SETTLE_CYC - 1);

  logic [DUR_W-1:0]    dur_q, dur_d;
  logic                dur_en;
  logic                armed_q, armed_d;
  logic                armed_en;
  logic [SETTLE_W-1:0] settle_q, settle_d;
  logic                settle_en;
  logic                set_acc, clr_acc;

  assign set_acc = arm_set_i & awake_i;
  assign clr_acc = arm_clr_i & awake_i & ~arm_set_i;

  // duration register: retained storage, no reset
  always_comb begin
    dur_en = dur_we_i & awake_i;
    dur_d  = dur_i;
  end

  always_ff @(posedge clk_i) begin
    if (dur_en) begin
      dur_q <= dur_d;
    end
  end

  // arm bit and its settle counter
  always_comb begin
    armed_en  = set_acc | clr_acc;
    armed_d   = set_acc;
    settle_en = 1'b0;
    settle_d  = settle_q;
    if (set_acc) begin
      settle_en = 1'b1;
      settle_d  = '0;
    end else if (armed_q && settle_q != SETTLE_LAST) begin
      settle_en = 1'b1;
      settle_d  = settle_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      settle_q <= '0;
    end else begin
      if (armed_en) begin
        armed_q <= armed_d;
      end
      if (settle_en) begin
        settle_q <= settle_d;
      end
    end
  end

  assign dur_o         = dur_q;
  assign arm_load_o    = set_acc;
  assign armed_ready_o = armed_q & ~set_acc & (settle_q == SETTLE_LAST);

  assert_frozen_asleep_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(awake_i) |-> ($stable(dur_q) && $stable(armed_q)))
    else $error("configuration changed while asleep");

endmodule

// File: rtl/swt_countdown.sv
module swt_countdown
  import swt_pkg::*;
#(
  parameter int DUR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             req_i,
  input  logic             arm_load_i,
  input  logic             armed_ready_i,
  input  logic [DUR_W-1:0] dur_i,
  output logic             wake_o,
  output logic             flag_o
);

  swt_state_e       state_q, state_d;
  logic [DUR_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             flag_q, flag_d;
  logic             flag_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    flag_d  = flag_q;
    flag_en = 1'b0;
    case (state_q)
      SWT_AWAKE: begin
        if (arm_load_i) begin
          cnt_en = 1'b1;
          cnt_d  = dur_i;
        end
        if (req_i) begin
          flag_en = 1'b1;
          flag_d  = 1'b0;
          if (armed_ready_i) begin
            state_d = SWT_COUNT;
            cnt_en  = 1'b1;
            cnt_d   = dur_i;
          end else begin
            state_d = SWT_HALT;
          end
        end
      end
      SWT_COUNT: begin
        if (tick_i) begin
          if (cnt_q == '0) begin
            state_d = SWT_AWAKE;
            flag_en = 1'b1;
            flag_d  = 1'b1;
          end else begin
            cnt_en = 1'b1;
            cnt_d  = cnt_q - 1'b1;
          end
        end
      end
      SWT_HALT: begin
        state_d = SWT_HALT;
      end
      default: begin
        state_d = SWT_AWAKE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SWT_AWAKE;
      cnt_q   <= '0;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
      if (flag_en) begin
        flag_q <= flag_d;
      end
    end
  end

  assign wake_o = (state_q == SWT_AWAKE);
  assign flag_o = flag_q;

  assert_req_sleeps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && req_i) |=> (!wake_o && !flag_o))
    else $error("request did not drop wake");

  assert_flag_with_wake_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |-> wake_o)
    else $error("timer flag set while asleep");

  assert_halt_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SWT_HALT) |=> (state_q == SWT_HALT))
    else $error("left idle sleep without reset");

  assert_wake_needs_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SWT_COUNT && !tick_i) |=> (state_q == SWT_COUNT))
    else $error("countdown ended without a tick");

  assert_one_step_per_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SWT_COUNT && tick_i && cnt_q != '0) |=>
      (state_q == SWT_COUNT && cnt_q == $past(cnt_q) - 1'b1))
    else $error("tick did not decrement by one");

endmodule

// File: rtl/swt_release.sv
module swt_release #(
  parameter int RELEASE_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_i,
  output logic cpu_run_o
);

  logic [RELEASE_STAGES-1:0] rel_q, rel_d;

  generate
    if (RELEASE_STAGES == 1) begin : g_single
      always_comb rel_d = wake_i;
    end else begin : g_chain
      always_comb rel_d = {rel_q[RELEASE_STAGES-2:0], wake_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_q <= '1;
    end else begin
      rel_q <= rel_d;
    end
  end

  // falling wake holds the processor at once; rising wake releases late
  assign cpu_run_o = wake_i & rel_q[RELEASE_STAGES-1];

  assert_run_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wake_i |-> !cpu_run_o)
    else $error("processor running while wake low");

endmodule

// File: rtl/sleep_wake_timer.sv
module sleep_wake_timer #(
  parameter int DUR_W          = 8,
  parameter int SETTLE_CYC     = 3,
  parameter int SYNC_STAGES    = 2,
  parameter int RELEASE_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pps_i,
  input  logic             dur_we_i,
  input  logic [DUR_W-1:0] dur_i,
  input  logic             arm_set_i,
  input  logic             arm_clr_i,
  input  logic             sleep_req_i,
  input  logic             lcd_req_i,
  output logic             wake_o,
  output logic             cpu_run_o,
  output logic             tmr_flag_o
);

  logic             tick;
  logic             wake;
  logic             req;
  logic             arm_load;
  logic             armed_ready;
  logic [DUR_W-1:0] dur_held;

  assign req = sleep_req_i | lcd_req_i;

  swt_tick_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pps_i (pps_i),
    .tick_o(tick)
  );

  swt_arm_ctrl #(
    .DUR_W     (DUR_W),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_arm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .awake_i      (wake),
    .dur_we_i     (dur_we_i),
    .dur_i        (dur_i),
    .arm_set_i    (arm_set_i),
    .arm_clr_i    (arm_clr_i),
    .dur_o        (dur_held),
    .arm_load_o   (arm_load),
    .armed_ready_o(armed_ready)
  );

  swt_countdown #(
    .DUR_W(DUR_W)
  ) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .req_i        (req),
    .arm_load_i   (arm_load),
    .armed_ready_i(armed_ready),
    .dur_i        (dur_held),
    .wake_o       (wake),
    .flag_o       (tmr_flag_o)
  );

  swt_release #(
    .RELEASE_STAGES(RELEASE_STAGES)
  ) u_rel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wake_i   (wake),
    .cpu_run_o(cpu_run_o)
  );

  assign wake_o = wake;

endmodule

// File: tb/sleep_wake_timer_tb.sv
module sleep_wake_timer_tb;

  logic       clk;
  logic       rst_n;
  logic       pps;
  logic       dur_we;
  logic [7:0] dur;
  logic       arm_set;
  logic       arm_clr;
  logic       sleep_req;
  logic       lcd_req;
  logic       wake;
  logic       cpu_run;
  logic       tmr_flag;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  sleep_wake_timer u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pps_i      (pps),
    .dur_we_i   (dur_we),
    .dur_i      (dur),
    .arm_set_i  (arm_set),
    .arm_clr_i  (arm_clr),
    .sleep_req_i(sleep_req),
    .lcd_req_i  (lcd_req),
    .wake_o     (wake),
    .cpu_run_o  (cpu_run),
    .tmr_flag_o (tmr_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int exp_ticks(int d);
    return d + 1;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
  endtask

  task automatic write_dur(int v);
    @(negedge clk);
    dur_we = 1'b1;
    dur    = 8'(v);
    @(negedge clk);
    dur_we = 1'b0;
  endtask

  task automatic arm();
    @(negedge clk);
    arm_set = 1'b1;
    @(negedge clk);
    arm_set = 1'b0;
  endtask

  task automatic disarm();
    @(negedge clk);
    arm_clr = 1'b1;
    @(negedge clk);
    arm_clr = 1'b0;
  endtask

  task automatic request(bit use_lcd);
    @(negedge clk);
    if (use_lcd) lcd_req = 1'b1;
    else         sleep_req = 1'b1;
    @(negedge clk);
    lcd_req   = 1'b0;
    sleep_req = 1'b0;
  endtask

  // one tick; when exp_last is set this tick must end the countdown
  task automatic tick(int hold, bit exp_last, string tag);
    @(negedge clk);
    pps = 1'b1;
    cyc(2);
    if (exp_last) chk(wake == 1'b0, {tag, " R3 early"}, int'(wake), 0);
    cyc(1);
    chk(wake == exp_last, {tag, " R3 wake"}, int'(wake), int'(exp_last));
    if (exp_last) begin
      chk(tmr_flag == 1'b1, {tag, " R4 flag"}, int'(tmr_flag), 1);
      chk(cpu_run == 1'b0, {tag, " R5 run lag"}, int'(cpu_run), 0);
      cyc(2);
      chk(cpu_run == 1'b1, {tag, " R5 run rise"}, int'(cpu_run), 1);
    end
    cyc(hold);
    pps = 1'b0;
    cyc(4);
  endtask

  task automatic run_countdown(int d, int hold, string tag);
    for (int i = 1; i < exp_ticks(d); i++) begin
      tick(hold, 1'b0, tag);
    end
    tick(hold, 1'b1, tag);
  endtask

  task automatic check_asleep(string tag);
    chk(wake == 1'b0, {tag, " R2 wake"}, int'(wake), 0);
    chk(cpu_run == 1'b0, {tag, " R2 run"}, int'(cpu_run), 0);
    chk(tmr_flag == 1'b0, {tag, " R2 flag"}, int'(tmr_flag), 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; pps = 1'b0; dur_we = 1'b0; dur = '0;
    arm_set = 1'b0; arm_clr = 1'b0; sleep_req = 1'b0; lcd_req = 1'b0;
    cyc(3);
    chk(wake == 1'b1 && cpu_run == 1'b1, "R1 in reset", int'({wake, cpu_run}), 3);
    rst_n = 1'b1;
    cyc(2);
    chk(wake == 1'b1, "R1 wake", int'(wake), 1);
    chk(cpu_run == 1'b1, "R1 run", int'(cpu_run), 1);
    chk(tmr_flag == 1'b0, "R1 flag", int'(tmr_flag), 0);

    // basic sleep, duration 2
    write_dur(2);
    arm();
    cyc(1);
    request(1'b0);
    check_asleep("R2 sleep");
    run_countdown(2, 1, "basic");

    // R6: no re-arm, display-only request restarts the held duration
    cyc(3);
    chk(tmr_flag == 1'b1, "R4 flag hold", int'(tmr_flag), 1);
    request(1'b1);
    check_asleep("R6 relaunch");

    // R11: writes while asleep are ignored
    write_dur(9);
    disarm();
    arm();
    request(1'b0);
    chk(wake == 1'b0, "R11 req asleep", int'(wake), 0);
    run_countdown(2, 1, "R6 R11 held");

    // R11: still armed with old duration, R9 long ticks
    cyc(3);
    request(1'b0);
    check_asleep("R9 setup");
    run_countdown(2, 30, "R9 long");

    // R8: request two cycles after arm -> idle
    write_dur(4);
    arm();
    request(1'b0);
    check_asleep("R8 early");
    for (int i = 0; i < 8; i++) tick(1, 1'b0, "R8 idle");
    chk(tmr_flag == 1'b0, "R8 no flag", int'(tmr_flag), 0);

    // R10: duration survives reset
    do_reset();
    chk(wake == 1'b1, "R1 after reset", int'(wake), 1);
    arm();
    cyc(1);
    request(1'b1);
    check_asleep("R10 sleep");
    run_countdown(4, 1, "R10 retained");

    // R7: disarmed via clear
    cyc(2);
    disarm();
    cyc(3);
    request(1'b0);
    check_asleep("R7 cleared");
    for (int i = 0; i < 7; i++) tick(1, 1'b0, "R7 idle");
    chk(tmr_flag == 1'b0, "R7 no flag", int'(tmr_flag), 0);

    // R7: never armed since reset
    do_reset();
    request(1'b1);
    check_asleep("R7 never");
    for (int i = 0; i < 3; i++) tick(1, 1'b0, "R7 never idle");
    do_reset();

    // R8 at exactly three cycles, duration zero
    write_dur(0);
    arm();
    cyc(1);
    request(1'b0);
    check_asleep("R8 boundary");
    run_countdown(0, 1, "R8 R3 zero");

    // random mix
    for (int it = 0; it < 8; it++) begin
      int d;
      int gap;
      bit l;
      d   = int'($urandom_range(0, 6));
      gap = int'($urandom_range(1, 3));
      l   = 1'($urandom_range(0, 1));
      write_dur(d);
      arm();
      cyc(gap);
      request(l);
      check_asleep("R2 random");
      run_countdown(d, int'($urandom_range(0, 5)), "R3 random");
      cyc(2);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule